// File: doc/BRIEF.md
# Per-Gain Offset Calibration Engine

This block corrects converter samples for amplifier offset. It keeps one signed 24-bit offset word for each of eight amplifier gain codes. Every raw sample from the converter has the word of the gain in use subtracted from it, with saturation, and comes out one clock later together with a valid strobe and an active-low ready line.

The host reaches the block through a small byte-wide register port. A pointer register picks which offset word the three byte registers expose. The pointer is separate from the active gain, so words can be read out for storage and written back at power-up while a different gain is converting. Setting the calibrate bit in the control register starts a calibration. The block pauses the output stream and asks the front end to short the amplifier input. After a fixed number of conversions it stores the last shorted-input sample as the offset of the gain that was active when calibration began. It then clears the bit, pulses ready low and lets the output stream resume.

A calibration request made while conversions are stopped stays pending. It starts once conversions run again.

Top module: `gain_offset_cal`

## Requirements
- R1: After reset all eight offset words read as zero, the control register reads 0x00, `rdy_n` is 1, and `out_valid` and `short_req` are 0.
- R2: `reg_sel` codes are:
  - 0: pointer, bits 2:0.
  - 1: high byte (bits 23:16) of the word at the pointer.
  - 2: mid byte (bits 15:8) of that word.
  - 3: low byte (bits 7:0) of that word.
  - 4: control, where bit 2 is the calibrate bit.
  
  `reg_rdata` shows the selected register in the same cycle.
- R3: The byte registers always address the word chosen by the pointer, whatever `gain_sel` is.
- R4: A byte write changes only that byte of the pointed word. The three bytes may be written in any order.
- R5: A sample accepted with `raw_valid` appears one cycle later on `out_data` as `raw_data` minus the word for the current `gain_sel`. At the same time `out_valid` is 1 and `rdy_n` is 0.
- R6: The subtraction saturates. Results above 0x7FFFFF give 0x7FFFFF, and results below -0x800000 give 0x800000.
- R7: Writing control with bit 2 = 1 sets the calibrate bit. While calibration runs, `short_req` is 1 and no `out_valid` is produced.
- R8: The 5th valid sample after calibration becomes active is stored raw into the word of the gain latched at activation. In the following cycle the calibrate bit reads 0, `short_req` is 0 and `rdy_n` is low for one cycle. Normal corrected output then resumes.
- R9: While `conv_run` is 0 a pending calibration does not start: `short_req` stays 0 and the bit stays 1. It starts the cycle after `conv_run` returns to 1.
- R10: If a calibration store and a host byte write hit the same word in the same cycle, the calibration value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| gain_sel | input | 3 | Active amplifier gain code |
| conv_run | input | 1 | Continuous conversions enabled |
| raw_valid | input | 1 | Raw sample strobe |
| raw_data | input | 24 | Raw signed sample |
| short_req | output | 1 | Short amplifier input (calibrating) |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 24 | Corrected signed sample |
| rdy_n | output | 1 | Active-low ready: output word or calibration done |

## Verification
The calibration store and a host byte write can both update the offset bank in the same clock. The bench provokes this by driving the final shorted-input sample in the same cycle as a high-byte write to the word of the gain being calibrated. It then reads that word back through the byte registers and expects the full calibration value with the host byte discarded.

// File: rtl/gain_cal_pkg.sv
package gain_cal_pkg;
    typedef enum logic [2:0] {
        SEL_PTR  = 3'd0,
        SEL_HI   = 3'd1,
        SEL_MID  = 3'd2,
        SEL_LO   = 3'd3,
        SEL_CTRL = 3'd4
    } reg_sel_e;

    localparam int CAL_BIT = 2;
endpackage

// File: rtl/offset_bank.sv
module offset_bank #(
    parameter int IW = 3,
    parameter int W  = 24,
    localparam int N  = 1 << IW,
    localparam int NB = W / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_we,
    input  logic [IW-1:0]         byte_idx,
    input  logic [$clog2(NB)-1:0] byte_lane,
    input  logic [7:0]            byte_data,
    input  logic                  word_we,
    input  logic [IW-1:0]         word_idx,
    input  logic [W-1:0]          word_data,
    input  logic [IW-1:0]         rd_idx_a,
    input  logic [IW-1:0]         rd_idx_b,
    output logic [W-1:0]          rd_a,
    output logic [W-1:0]          rd_b
);
    typedef struct packed {
        logic [N-1:0][W-1:0] bank;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (byte_we)
            st_d.bank[byte_idx][int'(byte_lane)*8 +: 8] = byte_data;
        // calibration store is applied last so it wins a collision
        if (word_we)
            st_d.bank[word_idx] = word_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_a = st_q.bank[rd_idx_a];
    assign rd_b = st_q.bank[rd_idx_b];
endmodule

// File: rtl/sat_sub.sv
module sat_sub #(
    parameter int W = 24
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W:0] diff;

    always_comb begin
        diff = {minuend[W-1], minuend} - {subtrahend[W-1], subtrahend};
        if (diff[W] != diff[W-1])
            result = diff[W] ? MAX_NEG : MAX_POS;
        else
            result = diff[W-1:0];
    end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl #(
    parameter int GW      = 3,
    parameter int SAMPLES = 5,
    localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          conv_run,
    input  logic          raw_valid,
    input  logic [GW-1:0] gain_sel,
    output logic          busy,
    output logic          active,
    output logic          done,
    output logic          store_we,
    output logic [GW-1:0] store_idx
);
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

    typedef struct packed {
        logic          pend;
        logic          act;
        logic          done;
        logic [CW-1:0] cnt;
        logic [GW-1:0] gain;
    } cal_st_t;

    cal_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        store_we  = 1'b0;
        if (st_q.pend && !st_q.act && conv_run) begin
            st_d.act  = 1'b1;
            st_d.cnt  = '0;
            st_d.gain = gain_sel;
        end
        if (st_q.act && raw_valid) begin
            if (st_q.cnt == LAST) begin
                store_we  = 1'b1;
                st_d.act  = 1'b0;
                st_d.pend = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (start)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.pend;
    assign active    = st_q.act;
    assign done      = st_q.done;
    assign store_idx = st_q.gain;

    // R8: a running calibration always has its request bit set
    a_r8_act_has_pend: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act |-> st_q.pend);

    // R8: completion indication lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R9: no calibration starts while conversions are stopped
    a_r9_held_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_run && !st_q.act) |=> !st_q.act);
endmodule

// File: rtl/gain_offset_cal.sv
module gain_offset_cal #(
    parameter int GAIN_W      = 3,
    parameter int WORD_W      = 24,
    parameter int CAL_SAMPLES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [GAIN_W-1:0] gain_sel,
    input  logic              conv_run,
    input  logic              raw_valid,
    input  logic [WORD_W-1:0] raw_data,
    output logic              short_req,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              rdy_n
);
    import gain_cal_pkg::*;

    localparam int NB = WORD_W / 8;
    localparam int LW = $clog2(NB);

    typedef struct packed {
        logic [GAIN_W-1:0] ptr;
        logic              ov;
        logic [WORD_W-1:0] od;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              cal_busy, cal_active, cal_done, store_we;
    logic [GAIN_W-1:0] store_idx;
    logic              byte_we, start;
    logic [LW-1:0]     lane;
    logic [WORD_W-1:0] ptr_word, act_word, corrected;

    always_comb begin
        byte_we = 1'b0;
        lane    = '0;
        case (reg_sel_e'(reg_sel))
            SEL_HI:  begin byte_we = reg_wr; lane = LW'(NB - 1); end
            SEL_MID: begin byte_we = reg_wr; lane = LW'(1);      end
            SEL_LO:  begin byte_we = reg_wr; lane = '0;          end
            default: ;
        endcase
        start = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL) && reg_wdata[CAL_BIT];
    end

    offset_bank #(.IW(GAIN_W), .W(WORD_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .byte_we(byte_we), .byte_idx(st_q.ptr), .byte_lane(lane), .byte_data(reg_wdata),
        .word_we(store_we), .word_idx(store_idx), .word_data(raw_data),
        .rd_idx_a(st_q.ptr), .rd_idx_b(gain_sel),
        .rd_a(ptr_word), .rd_b(act_word)
    );

    cal_ctrl #(.GW(GAIN_W), .SAMPLES(CAL_SAMPLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .conv_run(conv_run),
        .raw_valid(raw_valid), .gain_sel(gain_sel),
        .busy(cal_busy), .active(cal_active), .done(cal_done),
        .store_we(store_we), .store_idx(store_idx)
    );

    sat_sub #(.W(WORD_W)) u_sub (
        .minuend(raw_data), .subtrahend(act_word), .result(corrected)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ov = raw_valid && !cal_active;
        if (raw_valid && !cal_active)
            st_d.od = corrected;
        if (reg_wr && reg_sel_e'(reg_sel) == SEL_PTR)
            st_d.ptr = reg_wdata[GAIN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_sel))
            SEL_PTR:  reg_rdata = 8'(st_q.ptr);
            SEL_HI:   reg_rdata = ptr_word[(NB-1)*8 +: 8];
            SEL_MID:  reg_rdata = ptr_word[8 +: 8];
            SEL_LO:   reg_rdata = ptr_word[7:0];
            SEL_CTRL: reg_rdata[CAL_BIT] = cal_busy;
            default:  ;
        endcase
    end

    assign short_req = cal_active;
    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign rdy_n     = !(st_q.ov || cal_done);

    // R7: a cycle spent calibrating yields no corrected output next cycle
    a_r7_paused_output: assert property (@(posedge clk) disable iff (!rst_n)
        short_req |=> !out_valid);
endmodule

// File: tb/tb_gain_offset_cal.sv
module tb_gain_offset_cal;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [2:0]  gain_sel = '0;
    logic        conv_run = 1'b1;
    logic        raw_valid = 1'b0;
    logic [23:0] raw_data = '0;
    logic        short_req, out_valid, rdy_n;
    logic [23:0] out_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gain_offset_cal dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gain_sel(gain_sel),
        .conv_run(conv_run), .raw_valid(raw_valid), .raw_data(raw_data),
        .short_req(short_req), .out_valid(out_valid), .out_data(out_data),
        .rdy_n(rdy_n)
    );

    localparam logic [23:0] V_OFF [8] = '{24'h000000, 24'h000010, 24'hFFFFF0, 24'h000001,
                                          24'hFFFFFF, 24'h7FFFFF, 24'h800000, 24'h123456};
    localparam logic [23:0] V_RAW [8] = '{24'h123456, 24'h000100, 24'h000000, 24'h800000,
                                          24'h7FFFFF, 24'h800005, 24'h000000, 24'h123456};
    localparam logic [23:0] V_EXP [8] = '{24'h123456, 24'h0000F0, 24'h000010, 24'h800000,
                                          24'h7FFFFF, 24'h800000, 24'h7FFFFF, 24'h000000};

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(posedge clk); #1;
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] d);
        reg_sel = sel; #1;
        d = reg_rdata;
    endtask

    task automatic rd_word(input logic [2:0] g, output logic [23:0] w);
        logic [7:0] h, m, l;
        wr(3'd0, 8'(g));
        rd(3'd1, h); rd(3'd2, m); rd(3'd3, l);
        w = {h, m, l};
    endtask

    task automatic put_word(input logic [2:0] g, input logic [23:0] w);
        wr(3'd0, 8'(g));
        wr(3'd3, w[7:0]);      // low first: any byte order accepted
        wr(3'd1, w[23:16]);
        wr(3'd2, w[15:8]);
    endtask

    task automatic sample(input logic [23:0] d);
        @(posedge clk); #1;
        raw_valid = 1'b1; raw_data = d;
        @(posedge clk); #1;
        raw_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 24'h1, 24'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [23:0] w;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check("R1 rdy_n", 24'(rdy_n), 24'h1);
        check("R1 out_valid", 24'(out_valid), 24'h0);
        check("R1 short_req", 24'(short_req), 24'h0);
        rd(3'd4, b); check("R1 control", 24'(b), 24'h0);
        for (int g = 0; g < 8; g++) begin
            rd_word(3'(g), w);
            check("R1 entry zero", w, 24'h0);
        end

        // R5 R6 R4: vector table walk
        for (int i = 0; i < 8; i++) begin
            put_word(3'(i), V_OFF[i]);
            gain_sel = 3'(i);
            sample(V_RAW[i]);
            check("R5 out_valid", 24'(out_valid), 24'h1);
            check("R5 rdy_n low", 24'(rdy_n), 24'h0);
            check(i >= 3 && i <= 6 ? "R6 saturate" : "R5 subtract", out_data, V_EXP[i]);
        end

        // R2 R3: pointer independent of active gain
        gain_sel = 3'd3;
        rd_word(3'd5, w); check("R3 read ptr=5", w, 24'h7FFFFF);
        rd(3'd0, b); check("R2 ptr readback", 24'(b), 24'h5);
        rd_word(3'd6, w); check("R3 read ptr=6", w, 24'h800000);

        // R4: single byte write touches only that byte
        wr(3'd0, 8'd7); wr(3'd2, 8'hAA);
        rd_word(3'd7, w); check("R4 mid byte only", w, 24'h12AA56);

        // R7 R8: calibration on gain 2
        gain_sel = 3'd2; conv_run = 1'b1;
        wr(3'd4, 8'h04);
        rd(3'd4, b); check("R7 bit set", 24'(b), 24'h4);
        @(posedge clk); #1;
        check("R7 short_req", 24'(short_req), 24'h1);
        for (int k = 0; k < 4; k++) begin
            sample(24'h000011);
            check("R7 no output", 24'(out_valid), 24'h0);
        end
        sample(24'h000020);
        check("R8 rdy_n done", 24'(rdy_n), 24'h0);
        check("R8 short_req off", 24'(short_req), 24'h0);
        check("R8 no out_valid", 24'(out_valid), 24'h0);
        rd(3'd4, b); check("R8 bit clear", 24'(b), 24'h0);
        rd_word(3'd2, w); check("R8 stored", w, 24'h000020);
        sample(24'h000030);
        check("R8 resumed", out_data, 24'h000010);
        check("R8 resumed valid", 24'(out_valid), 24'h1);

        // R9: request held while stopped
        conv_run = 1'b0; gain_sel = 3'd0;
        wr(3'd4, 8'h04);
        repeat (5) @(posedge clk);
        #1;
        check("R9 no short", 24'(short_req), 24'h0);
        rd(3'd4, b); check("R9 bit held", 24'(b), 24'h4);
        conv_run = 1'b1;
        @(posedge clk); #1;
        check("R9 starts", 24'(short_req), 24'h1);
        for (int k = 0; k < 4; k++) sample(24'h000001);
        sample(24'hFFFFF0);
        rd_word(3'd0, w); check("R9 stored", w, 24'hFFFFF0);
        sample(24'h000000);
        check("R9 resumed", out_data, 24'h000010);

        // R10: calibration store collides with host byte write
        gain_sel = 3'd4;
        wr(3'd0, 8'd4);
        wr(3'd4, 8'h04);
        @(posedge clk); #1;
        for (int k = 0; k < 4; k++) sample(24'h000002);
        @(posedge clk); #1;
        raw_valid = 1'b1; raw_data = 24'h000ABC;
        reg_sel = 3'd1; reg_wdata = 8'h55; reg_wr = 1'b1;
        @(posedge clk); #1;
        raw_valid = 1'b0; reg_wr = 1'b0;
        rd_word(3'd4, w); check("R10 cal wins", w, 24'h000ABC);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule